// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block receives the divider settings of a frequency synthesizer over a three-wire serial link and presents them as parallel fields. A serial clock, a data line and two strobes steer each bit. With both strobes low, bits enter a 21-bit main word; with the extended-control strobe high, they enter a short control word instead. Each word has its own holding register, so the settings in use never change while a new word is being shifted in. The main word is committed when its strobe rises. The control word is committed when its strobe falls.

The committed main word supplies the reference divider, the main divider, the swallow count and the prescaler-bypass flag. A parallel mode takes the four fields from pins instead and freezes the serial path. The committed control word drives a power-down flag, a forced-load flag and a lock-detect disable. It also selects which internal tap appears on a single debug output. An active-low enable gates every control effect. All serial pins are brought into the `clk` domain through synchronizers. `rst_n` is asserted asynchronously and is expected to be released in step with `clk`.

Top module: `synth_cfg_loader`

## Requirements
- R1: Serial data is sampled on each rising edge of `ser_clk`, and the first bit received ends up as the most significant bit of its word.
- R2: A rising edge of `ser_clk` shifts the main word when `prim_strobe`=0 and `xctl_sel`=0. It shifts the control word when `prim_strobe`=0 and `xctl_sel`=1. It shifts neither word while `prim_strobe`=1.
- R3: The committed divider fields change only on a rising edge of `prim_strobe`. At that edge they take the last 21 bits shifted into the main word, and they hold unchanged while shifting is in progress.
- R4: The main word, from the first bit received to the last, is: r_div[5], r_div[4], m_div[8], m_div[7], presc_bypass, m_div[6] down to m_div[0], r_div[3] down to r_div[0], a_div[3] down to a_div[0], then one address bit that is discarded.
- R5: The committed control word changes only on a falling edge of `xctl_sel`. At that edge it takes the last 8 bits shifted into the control word, and it holds unchanged while shifting is in progress.
- R6: Control bit k is the k-th bit received, counting from 0. Bits 0 and 1 have no effect. A 1 in bit 3 sets `power_down`, a 1 in bit 4 sets `load_force`, and a 1 in bit 7 sets `lock_det_off`.
- R7: While `xctl_en_n`=1, `power_down`, `load_force`, `lock_det_off` and `dbg_out` are all 0, whatever the committed control word holds.
- R8: `dbg_out` follows `mdiv_tap` when control bit 2 is set. Otherwise it follows `msel_tap` when bit 5 is set. Otherwise it follows `rdiv_tap` when bit 6 is set. Otherwise it is 0.
- R9: While `par_mode`=1, the fields come straight from `par_r`, `par_m`, `par_a` and `par_bypass`, and serial activity changes neither committed word. When `par_mode` returns to 0, the earlier serial settings reappear.
- R10: After reset, every field and every control output is 0.
- R11: A change of level on a serial pin takes effect at the third rising edge of `clk` that sees the new level. Each level must therefore be held for at least three `clk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data, first bit is MSB |
| prim_strobe | input | 1 | Main-word strobe: low enables shifting, a rising edge commits |
| xctl_sel | input | 1 | Control-word select: high steers bits, a falling edge commits |
| xctl_en_n | input | 1 | Active-low enable of control-word effects |
| par_mode | input | 1 | 1 selects parallel pins for the fields |
| par_r | input | 6 | Parallel reference divider value |
| par_m | input | 9 | Parallel main divider value |
| par_a | input | 4 | Parallel swallow count |
| par_bypass | input | 1 | Parallel prescaler bypass flag |
| mdiv_tap | input | 1 | Main-divider output tap for debug |
| msel_tap | input | 1 | Modulus-select tap for debug |
| rdiv_tap | input | 1 | Reference-divider output tap for debug |
| r_div | output | 6 | Reference divider field |
| m_div | output | 9 | Main divider field |
| a_div | output | 4 | Swallow count field |
| presc_bypass | output | 1 | Prescaler bypass flag |
| power_down | output | 1 | Power-down request |
| load_force | output | 1 | Immediate, continuous counter load |
| lock_det_off | output | 1 | Lock-detect disable |
| dbg_out | output | 1 | Selected debug tap |

## Verification
Main words are loaded with asymmetric values and with their bit complements. A swapped field, a split-field error or a reversed shift direction therefore gives a visibly different result. A load is stopped partway through and the outputs are observed, which shows whether the commit really waits for the strobe edge. The same is done for a set of bits clocked while `prim_strobe` is high, which shows whether shifting is gated. Control bytes with one route bit set are told apart from bytes with two or three route bits set, which exposes the debug priority. A load made in parallel mode is followed by a return to serial mode, which shows whether the serial state was frozen.

// File: rtl/synth_cfg_pkg.sv
`timescale 1ns/1ps
package synth_cfg_pkg;
  // control word bit positions (bit k = k-th bit received)
  localparam int XB_FIRST = 2;   // bits below this are reserved
  localparam int XB_FP    = 2;
  localparam int XB_PDN   = 3;
  localparam int XB_LOAD  = 4;
  localparam int XB_MSEL  = 5;
  localparam int XB_FC    = 6;
  localparam int XB_LDOFF = 7;
  localparam int XCTL_W   = 8;
  localparam int XCTL_KEEP = XCTL_W - XB_FIRST;

  typedef struct packed {
    logic ldoff;
    logic load;
    logic pdn;
  } xctl_eff_t;
endpackage

// File: rtl/synth_cfg_sync.sv
`timescale 1ns/1ps
module synth_cfg_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg_d [STAGES];
  logic [N-1:0] stg_q [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/synth_cfg_shreg.sv
`timescale 1ns/1ps
module synth_cfg_shreg #(
  parameter int W    = 21,
  parameter int LO   = 0,
  parameter int KEEP = W - LO
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [KEEP-1:0] q
);
  logic [W-1:0] sr_d, sr_q;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[LO +: KEEP];

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[0] == $past(din)) && (sr_q[W-1:1] == $past(sr_q[W-2:0]))); // R1
endmodule

// File: rtl/synth_cfg_dbg_mux.sv
`timescale 1ns/1ps
module synth_cfg_dbg_mux #(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0] route,  // index 0 has highest priority
  input  logic [NSRC-1:0] tap,
  output logic            dout
);
  always_comb begin
    dout = 1'b0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (route[i]) dout = tap[i];
    end
  end
endmodule

// File: rtl/synth_cfg_loader.sv
`timescale 1ns/1ps
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int R_W         = 6,
  parameter int M_W         = 9,
  parameter int A_W         = 4,
  parameter int R_HI        = 2,
  parameter int M_HI        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           prim_strobe,
  input  logic           xctl_sel,
  input  logic           xctl_en_n,
  input  logic           par_mode,
  input  logic [R_W-1:0] par_r,
  input  logic [M_W-1:0] par_m,
  input  logic [A_W-1:0] par_a,
  input  logic           par_bypass,
  input  logic           mdiv_tap,
  input  logic           msel_tap,
  input  logic           rdiv_tap,
  output logic [R_W-1:0] r_div,
  output logic [M_W-1:0] m_div,
  output logic [A_W-1:0] a_div,
  output logic           presc_bypass,
  output logic           power_down,
  output logic           load_force,
  output logic           lock_det_off,
  output logic           dbg_out
);
  // main word layout, index 0 = last bit received (address, discarded)
  localparam int R_LO   = R_W - R_HI;
  localparam int M_LO   = M_W - M_HI;
  localparam int A_LSB  = 1;
  localparam int RL_LSB = A_LSB + A_W;
  localparam int ML_LSB = RL_LSB + R_LO;
  localparam int PB_POS = ML_LSB + M_LO;
  localparam int MH_LSB = PB_POS + 1;
  localparam int RH_LSB = MH_LSB + M_HI;
  localparam int PW     = RH_LSB + R_HI;
  localparam int SW     = PW - 1;

  // ---------------- input synchronization and edge detection
  logic [3:0] syn;
  logic [2:0] prv_d, prv_q;
  logic       sclk_rise, swr_rise, ewr_fall;
  logic       swr_lvl, ewr_lvl, sdat;

  synth_cfg_sync #(.N(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_clk, ser_data, prim_strobe, xctl_sel}),
    .q     (syn)
  );

  assign sdat    = syn[2];
  assign swr_lvl = syn[1];
  assign ewr_lvl = syn[0];
  assign prv_d   = {syn[3], syn[1], syn[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= '0;
    else        prv_q <= prv_d;
  end

  assign sclk_rise = syn[3] & ~prv_q[2];
  assign swr_rise  = swr_lvl & ~prv_q[1];
  assign ewr_fall  = ~ewr_lvl & prv_q[0];

  // ---------------- shift registers
  logic             prim_shift, xctl_shift;
  logic [SW-1:0]    psr_q;
  logic [XCTL_KEEP-1:0] xsr_q;

  assign prim_shift = sclk_rise & ~swr_lvl & ~ewr_lvl & ~par_mode;
  assign xctl_shift = sclk_rise & ~swr_lvl &  ewr_lvl & ~par_mode;

  synth_cfg_shreg #(.W(PW), .LO(1), .KEEP(SW)) u_prim_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (prim_shift),
    .din      (sdat),
    .q        (psr_q)
  );

  // reserved bits arrive first and fall off the end of a shorter register
  synth_cfg_shreg #(.W(XCTL_KEEP), .LO(0), .KEEP(XCTL_KEEP)) u_xctl_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (xctl_shift),
    .din      (sdat),
    .q        (xsr_q)
  );

  // ---------------- holding registers
  logic                 sec_en, xbuf_en;
  logic [SW-1:0]        sec_d, sec_q;
  logic [XCTL_KEEP-1:0] xbuf_ord, xbuf_d, xbuf_q;

  // xbuf index j holds control bit j+XB_FIRST
  for (genvar k = XB_FIRST; k < XCTL_W; k++) begin : g_xord
    assign xbuf_ord[k-XB_FIRST] = xsr_q[XCTL_W-1-k];
  end

  assign sec_en  = swr_rise & ~par_mode;
  assign xbuf_en = ewr_fall & ~par_mode;

  always_comb begin
    sec_d  = sec_q;
    xbuf_d = xbuf_q;
    if (sec_en)  sec_d  = psr_q;
    if (xbuf_en) xbuf_d = xbuf_ord;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      xbuf_q <= '0;
    end else begin
      sec_q  <= sec_d;
      xbuf_q <= xbuf_d;
    end
  end

  // ---------------- field decode and source select
  logic [R_W-1:0] ser_r;
  logic [M_W-1:0] ser_m;
  logic [A_W-1:0] ser_a;
  logic           ser_pb;

  assign ser_r  = {sec_q[RH_LSB-1 +: R_HI], sec_q[RL_LSB-1 +: R_LO]};
  assign ser_m  = {sec_q[MH_LSB-1 +: M_HI], sec_q[ML_LSB-1 +: M_LO]};
  assign ser_a  = sec_q[A_LSB-1 +: A_W];
  assign ser_pb = sec_q[PB_POS-1];

  always_comb begin
    if (par_mode) begin
      r_div        = par_r;
      m_div        = par_m;
      a_div        = par_a;
      presc_bypass = par_bypass;
    end else begin
      r_div        = ser_r;
      m_div        = ser_m;
      a_div        = ser_a;
      presc_bypass = ser_pb;
    end
  end

  // ---------------- control effects
  logic [XCTL_KEEP-1:0] xeff;
  xctl_eff_t            eff;

  assign xeff = xctl_en_n ? '0 : xbuf_q;
  assign eff  = '{ldoff: xeff[XB_LDOFF-XB_FIRST],
                  load:  xeff[XB_LOAD-XB_FIRST],
                  pdn:   xeff[XB_PDN-XB_FIRST]};

  assign power_down   = eff.pdn;
  assign load_force   = eff.load;
  assign lock_det_off = eff.ldoff;

  synth_cfg_dbg_mux #(.NSRC(3)) u_dbg (
    .route ({xeff[XB_FC-XB_FIRST], xeff[XB_MSEL-XB_FIRST], xeff[XB_FP-XB_FIRST]}),
    .tap   ({rdiv_tap, msel_tap, mdiv_tap}),
    .dout  (dbg_out)
  );

  // ---------------- assertions
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(swr_rise && !par_mode) |=> $stable(sec_q)); // R3

  AST_XBUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ewr_fall && !par_mode) |=> $stable(xbuf_q)); // R5

  AST_PAR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> ($stable(sec_q) && $stable(xbuf_q))); // R9

  AST_XCTL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    xctl_en_n |-> (!power_down && !load_force && !lock_det_off && !dbg_out)); // R7

  AST_DBG_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!xctl_en_n && xbuf_q[XB_FP-XB_FIRST]) |-> (dbg_out == mdiv_tap)); // R8
endmodule

// File: tb/test_synth_cfg_loader.sv
`timescale 1ns/1ps
module test_synth_cfg_loader;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk, ser_data, prim_strobe, xctl_sel, xctl_en_n, par_mode;
  logic [5:0] par_r;
  logic [8:0] par_m;
  logic [3:0] par_a;
  logic       par_bypass, mdiv_tap, msel_tap, rdiv_tap;
  logic [5:0] r_div;
  logic [8:0] m_div;
  logic [3:0] a_div;
  logic       presc_bypass, power_down, load_force, lock_det_off, dbg_out;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  synth_cfg_loader i_synth_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .prim_strobe(prim_strobe), .xctl_sel(xctl_sel), .xctl_en_n(xctl_en_n),
    .par_mode(par_mode), .par_r(par_r), .par_m(par_m), .par_a(par_a),
    .par_bypass(par_bypass), .mdiv_tap(mdiv_tap), .msel_tap(msel_tap),
    .rdiv_tap(rdiv_tap), .r_div(r_div), .m_div(m_div), .a_div(a_div),
    .presc_bypass(presc_bypass), .power_down(power_down),
    .load_force(load_force), .lock_det_off(lock_det_off), .dbg_out(dbg_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model
  typedef struct packed { logic sclk; logic sdata; logic swr; logic ewr; } snap_t;
  snap_t hist[$];
  bit pq[$], sq[$], xq[$], bq[$];   // index 0 = earliest bit of the word

  task automatic model_reset();
    hist = {};
    pq = {}; sq = {}; xq = {}; bq = {};
    for (int i = 0; i < 3; i++) hist.push_back('0);
    for (int i = 0; i < 21; i++) begin pq.push_back(1'b0); sq.push_back(1'b0); end
    for (int i = 0; i < 8; i++)  begin xq.push_back(1'b0); bq.push_back(1'b0); end
  endtask

  initial model_reset();

  always @(posedge clk) begin : mdl
    snap_t nw, od;
    if (!rst_n) model_reset();
    else begin
      hist.push_back({ser_clk, ser_data, prim_strobe, xctl_sel});
      while (hist.size() > 4) void'(hist.pop_front());
      nw = hist[1];  // level seen two edges ago (R11 latency)
      od = hist[0];
      if (!par_mode) begin
        if (nw.swr && !od.swr) sq = pq;
        if (!nw.ewr && od.ewr) bq = xq;
        if (nw.sclk && !od.sclk && !nw.swr) begin
          if (!nw.ewr) begin pq.push_back(nw.sdata); void'(pq.pop_front()); end
          else         begin xq.push_back(nw.sdata); void'(xq.pop_front()); end
        end
      end
    end
  end

  always @(negedge clk) begin : cmp
    logic [5:0] er; logic [8:0] em; logic [3:0] ea; logic epb, xe, edbg;
    if (rst_n === 1'b1 && !done) begin
      er  = {sq[0], sq[1], sq[12], sq[13], sq[14], sq[15]};
      em  = {sq[2], sq[3], sq[5], sq[6], sq[7], sq[8], sq[9], sq[10], sq[11]};
      ea  = {sq[16], sq[17], sq[18], sq[19]};
      epb = sq[4];
      if (par_mode) begin er = par_r; em = par_m; ea = par_a; epb = par_bypass; end
      xe = !xctl_en_n;
      if (!xe)        edbg = 1'b0;
      else if (bq[2]) edbg = mdiv_tap;
      else if (bq[5]) edbg = msel_tap;
      else if (bq[6]) edbg = rdiv_tap;
      else            edbg = 1'b0;
      chk("R4 model r_div", r_div, er);
      chk("R4 model m_div", m_div, em);
      chk("R4 model a_div", a_div, ea);
      chk("R4 model presc_bypass", presc_bypass, epb);
      chk("R6 model power_down", power_down, xe & bq[3]);
      chk("R6 model load_force", load_force, xe & bq[4]);
      chk("R6 model lock_det_off", lock_det_off, xe & bq[7]);
      chk("R8 model dbg_out", dbg_out, edbg);
    end
  end

  // ---------------- stimulus helpers (drive 2 ns after a rising edge)
  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic ser_bit(input logic b);
    ser_clk = 1'b0; ser_data = b; hold(4);
    ser_clk = 1'b1; hold(4);
  endtask

  task automatic shift_prim(input logic [5:0] r, input logic [8:0] m,
                            input logic [3:0] a, input logic pb, input int nbits);
    logic [20:0] w;
    w = {r[5:4], m[8:7], pb, m[6:0], r[3:0], a, 1'b0};
    prim_strobe = 1'b0; xctl_sel = 1'b0; hold(4);
    for (int i = 20; i > 20 - nbits; i--) ser_bit(w[i]);
    ser_clk = 1'b0; hold(4);
  endtask

  task automatic load_prim(input logic [5:0] r, input logic [8:0] m,
                           input logic [3:0] a, input logic pb);
    shift_prim(r, m, a, pb, 21);
    prim_strobe = 1'b1; hold(6);
  endtask

  task automatic load_xctl(input logic [7:0] b);
    prim_strobe = 1'b0; xctl_sel = 1'b1; hold(4);
    for (int k = 0; k < 8; k++) ser_bit(b[k]);
    ser_clk = 1'b0; hold(4);
    xctl_sel = 1'b0; hold(6);
    prim_strobe = 1'b1; hold(6);
  endtask

  task automatic chk_fields(input string tag, input logic [5:0] r, input logic [8:0] m,
                            input logic [3:0] a, input logic pb);
    chk({tag, " r_div"}, r_div, r);
    chk({tag, " m_div"}, m_div, m);
    chk({tag, " a_div"}, a_div, a);
    chk({tag, " presc_bypass"}, presc_bypass, pb);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- test sequence
  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; prim_strobe = 1'b1;
    xctl_sel = 1'b0; xctl_en_n = 1'b0; par_mode = 1'b0;
    par_r = '0; par_m = '0; par_a = '0; par_bypass = 1'b0;
    mdiv_tap = 1'b1; msel_tap = 1'b1; rdiv_tap = 1'b1;
    hold(5);
    @(negedge clk);
    chk_fields("R10 reset", 6'h0, 9'h0, 4'h0, 1'b0);
    chk("R10 reset power_down", power_down, 0);
    chk("R10 reset dbg_out", dbg_out, 0);
    hold(1);
    rst_n = 1'b1;
    hold(6);

    // R1 R4 R11: asymmetric word, latency of the commit strobe
    shift_prim(6'h2D, 9'h1A5, 4'hB, 1'b1, 21);
    prim_strobe = 1'b1;
    repeat (3) @(negedge clk);
    chk_fields("R11 before third edge", 6'h0, 9'h0, 4'h0, 1'b0);
    @(negedge clk);
    chk_fields("R11 R1 R4 after third edge", 6'h2D, 9'h1A5, 4'hB, 1'b1);
    hold(6);

    // R3: partial load keeps old fields, then complement word commits
    shift_prim(6'h12, 9'h05A, 4'h4, 1'b0, 10);
    chk_fields("R3 mid-shift hold", 6'h2D, 9'h1A5, 4'hB, 1'b1);
    load_prim(6'h12, 9'h05A, 4'h4, 1'b0);
    chk_fields("R3 R4 complement word", 6'h12, 9'h05A, 4'h4, 1'b0);

    // R2: bits clocked with prim_strobe high are ignored
    prim_strobe = 1'b1; xctl_sel = 1'b0; hold(4);
    for (int i = 0; i < 21; i++) ser_bit(1'b1);
    ser_clk = 1'b0; hold(4);
    prim_strobe = 1'b0; hold(4);
    prim_strobe = 1'b1; hold(6);
    chk_fields("R2 strobe-high bits ignored", 6'h12, 9'h05A, 4'h4, 1'b0);

    // R5 R6: control byte, hold before the falling edge of xctl_sel
    prim_strobe = 1'b0; xctl_sel = 1'b1; hold(4);
    for (int k = 0; k < 8; k++) ser_bit(k == 3 || k == 4);
    ser_clk = 1'b0; hold(4);
    chk("R5 hold before commit power_down", power_down, 0);
    xctl_sel = 1'b0; hold(6);
    prim_strobe = 1'b1; hold(6);
    chk("R6 bit3 power_down", power_down, 1);
    chk("R6 bit4 load_force", load_force, 1);
    chk("R6 bit7 lock_det_off", lock_det_off, 0);
    chk_fields("R2 control load leaves fields", 6'h12, 9'h05A, 4'h4, 1'b0);

    load_xctl(8'h83);  // bits 7, 1, 0
    chk("R6 bit7 lock_det_off", lock_det_off, 1);
    chk("R6 reserved bits no effect", {power_down, load_force, dbg_out}, 0);

    // R7: enable gating
    load_xctl(8'hFC);
    xctl_en_n = 1'b1; hold(2);
    chk("R7 gated outputs", {power_down, load_force, lock_det_off, dbg_out}, 0);
    xctl_en_n = 1'b0; hold(2);
    chk("R7 enabled outputs", {power_down, load_force, lock_det_off}, 3'b111);

    // R8: debug priority
    load_xctl(8'h64);  // bits 2,5,6
    mdiv_tap = 1'b0; msel_tap = 1'b1; rdiv_tap = 1'b1; hold(1);
    chk("R8 bit2 wins low", dbg_out, 0);
    mdiv_tap = 1'b1; hold(1);
    chk("R8 bit2 wins high", dbg_out, 1);
    load_xctl(8'h60);  // bits 5,6
    msel_tap = 1'b0; hold(1);
    chk("R8 bit5 over bit6", dbg_out, 0);
    load_xctl(8'h40);
    rdiv_tap = 1'b0; hold(1);
    chk("R8 bit6 low", dbg_out, 0);
    rdiv_tap = 1'b1; hold(1);
    chk("R8 bit6 high", dbg_out, 1);
    load_xctl(8'h00);
    chk("R8 no route", dbg_out, 0);

    // R9: parallel mode, serial path frozen
    load_xctl(8'h08);
    par_mode = 1'b1; par_r = 6'h3A; par_m = 9'h133; par_a = 4'h6; par_bypass = 1'b1;
    hold(2);
    chk_fields("R9 parallel fields", 6'h3A, 9'h133, 4'h6, 1'b1);
    load_prim(6'h01, 9'h0FF, 4'hF, 1'b1);
    load_xctl(8'h90);
    chk_fields("R9 parallel ignores serial", 6'h3A, 9'h133, 4'h6, 1'b1);
    chk("R9 control unchanged", {power_down, load_force, lock_det_off}, 3'b100);
    par_mode = 1'b0; hold(2);
    chk_fields("R9 serial restored", 6'h12, 9'h05A, 4'h4, 1'b0);

    hold(4);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule